// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits on the host side of a 32K x 8 pseudo-static RAM that has a plain, non-multiplexed address bus. It accepts one read or write at a time over a valid/ready handshake. It turns each request into the active-low chip-enable, write and output-enable strobes the memory expects. Every pulse width and gap is a count of system-clock cycles. The counts are derived at elaboration from nanosecond minimums divided by the clock period and rounded up, so a slower speed grade or a different clock only needs new parameter values.

After reset the sequencer runs the memory's power-up sequence on its own. It keeps every strobe inactive for the power-up wait, then issues a fixed number of dummy chip-enable cycles. Only after that does it raise `init_done` and begin accepting requests. Refresh is not scheduled here. The `busy` output tells a separate refresh scheduler when the memory bus is free. A read returns its byte with a one-cycle `rsp_valid` pulse. A write returns nothing.

The cycle counts below are for the default parameters (10 ns clock): an active window of 10 cycles, a precharge of 5 cycles, a write strobe of 6 cycles, and 8 dummy cycles.

Top module: `psram_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe`, `rsp_valid`, `req_ready` and `init_done` are 0, and `busy` is 1.
- R2: After reset is released, `mem_ce_n` and `mem_oe_n` stay high for at least the power-up wait, which is the power-up time divided by the clock period and rounded up. No chip-enable falls before that.
- R3: Before `init_done` rises, exactly DUMMY_N chip-enable pulses occur, each with `mem_we_n` and `mem_oe_n` held at 1. `req_ready` and `rsp_valid` stay 0 until then, and once `init_done` is 1 it stays 1.
- R4: Every chip-enable pulse, dummy or real, holds `mem_ce_n` at 0 for exactly ACT_C cycles. ACT_C is the largest of these rounded counts: the pulse width, the access time, the output-enable access time, the write pulse, the data setup, the address hold, and the cycle time minus the precharge minus one.
- R5: Between two chip-enable pulses, `mem_ce_n` is 1 for at least PRE_C cycles. Two successive falls of `mem_ce_n` are at least RC_C cycles apart.
- R6: For a read, `mem_oe_n` is 0 and `mem_we_n` is 1 on every cycle that `mem_ce_n` is 0. `rsp_valid` is then high for exactly one cycle, the first cycle `mem_ce_n` is back at 1. In that cycle `rsp_rdata` equals the byte last written to that address, or 0 for an address never written.
- R7: For a write, `mem_oe_n` stays 1 and `mem_we_n` is 0 for exactly the last WCP_C cycles of the chip-enable window, rising together with `mem_ce_n`. `mem_dq_oe` is 1 and `mem_wdata` is stable while `mem_we_n` is 0. A write produces no `rsp_valid`.
- R8: `mem_addr` equals the accepted request address and does not change while `mem_ce_n` is 0.
- R9: `req_ready` is always the inverse of `busy`. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 on the next cycle. `busy` stays 1 until the precharge interval has ended.
- R10: A request held valid during an access is taken as soon as the block is idle. Back-to-back accesses then have chip-enable falls exactly ACT_C + PRE_C + 1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 15 | Byte address of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data present |
| rsp_rdata | output | 8 | Read data |
| busy | output | 1 | Memory bus in use or not yet initialised |
| init_done | output | 1 | Power-up sequence finished |
| mem_addr | output | 15 | Memory address bus |
| mem_wdata | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_rdata | input | 8 | Data returned by the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
Checked on every cycle:
- The write strobe only falls inside a chip-enable window, and it is never low together with output enable.
- The address and the write data hold still while they are in use.
- A response only follows an output-enable cycle.
- Acceptance raises `busy`, and `init_done` never falls.

Shown only by the bench's scenarios, which measure these at the pins:
- The exact pulse widths, the precharge gaps and the back-to-back spacing.
- The number of dummy pulses and the length of the power-up wait.
- Whether the data read back matches what was written over a random mix of addresses.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_POWERUP = 2'd0,
        PH_IDLE    = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_PRECHG  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              dummy;
    } op_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // round a nanosecond minimum up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_powerup.sv
module psram_powerup #(
    parameter int PWR_C   = 20000,
    parameter int DUMMY_N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dummy_fin,
    output logic wait_done,
    output logic dummy_pending,
    output logic init_done
);
    localparam int WCNT_W = $clog2(PWR_C + 1);
    localparam int DCNT_W = $clog2(DUMMY_N + 1);

    logic [WCNT_W-1:0] wcnt_q;
    logic [DCNT_W-1:0] dcnt_q;

    assign wait_done     = (wcnt_q == WCNT_W'(PWR_C));
    assign init_done     = (dcnt_q == DCNT_W'(DUMMY_N));
    assign dummy_pending = wait_done && !init_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            dcnt_q <= '0;
        end else begin
            if (!wait_done)
                wcnt_q <= wcnt_q + WCNT_W'(1);
            if (dummy_fin && !init_done)
                dcnt_q <= dcnt_q + DCNT_W'(1);
        end
    end

    // R3: initialisation, once complete, is never undone
    p_init_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R3: the dummy count never passes its target
    p_dummy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        dcnt_q <= DCNT_W'(DUMMY_N));

endmodule

// File: rtl/psram_strobe_gen.sv
module psram_strobe_gen
    import psram_seq_pkg::*;
#(
    parameter int ACT_C = 10,
    parameter int WCP_C = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic             op_wr,
    input  logic             op_dummy,
    output strobe_t          stb,
    output logic             last_o
);
    localparam int WE_START = ACT_C - WCP_C;

    strobe_t stb_d;
    logic    last_d;
    logic    act;

    always_comb begin
        act          = (phase == PH_ACTIVE);
        stb_d.ce_n   = !act;
        stb_d.oe_n   = !(act && !op_wr && !op_dummy);
        stb_d.we_n   = !(act && op_wr && !op_dummy && (cnt >= CNT_W'(WE_START)));
        stb_d.dq_oe  = act && op_wr && !op_dummy;
        last_d       = act && (cnt == CNT_W'(ACT_C - 1));
    end

    // strobes leave the block straight from flops
    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            last_o <= 1'b0;
        end else begin
            stb    <= stb_d;
            last_o <= last_d;
        end
    end

    // R7: write strobe only inside a chip-enable window
    p_we_inside_ce_r7: assert property (@(posedge clk) disable iff (rst)
        !stb.we_n |-> !stb.ce_n);

    // R6: output enable and write strobe never overlap
    p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!stb.oe_n && !stb.we_n));

    // R4: a chip-enable pulse is never a single cycle
    p_ce_not_runt_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(stb.ce_n) |=> !stb.ce_n);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_seq_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int T_CE_NS   = 100,
    parameter int T_PRE_NS  = 50,
    parameter int T_RC_NS   = 160,
    parameter int T_CEA_NS  = 100,
    parameter int T_OEA_NS  = 40,
    parameter int T_WCP_NS  = 60,
    parameter int T_DSW_NS  = 40,
    parameter int T_AH_NS   = 20,
    parameter int PWRUP_NS  = 200000,
    parameter int DUMMY_N   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              init_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int CE_C  = ns_to_cyc(T_CE_NS,  CLK_NS);
    localparam int PRE_C = ns_to_cyc(T_PRE_NS, CLK_NS);
    localparam int RC_C  = ns_to_cyc(T_RC_NS,  CLK_NS);
    localparam int CEA_C = ns_to_cyc(T_CEA_NS, CLK_NS);
    localparam int OEA_C = ns_to_cyc(T_OEA_NS, CLK_NS);
    localparam int WCP_C = ns_to_cyc(T_WCP_NS, CLK_NS);
    localparam int DSW_C = ns_to_cyc(T_DSW_NS, CLK_NS);
    localparam int AH_C  = ns_to_cyc(T_AH_NS,  CLK_NS);
    localparam int PWR_C = ns_to_cyc(PWRUP_NS, CLK_NS);
    // one idle cycle always separates precharge from the next active window
    localparam int ACT_C = imax(imax(imax(CE_C, RC_C - PRE_C - 1), imax(CEA_C, OEA_C)),
                                imax(imax(WCP_C, DSW_C), AH_C));
    localparam int CNT_W = $clog2(imax(ACT_C, PRE_C) + 1);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    op_t              op_q;
    strobe_t          stb;
    logic             last_q;
    logic             wait_done, dummy_pending, dummy_fin;
    logic             start_dummy, start_req;
    logic             rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    psram_powerup #(
        .PWR_C   (PWR_C),
        .DUMMY_N (DUMMY_N)
    ) u_powerup (
        .clk           (clk),
        .rst           (rst),
        .dummy_fin     (dummy_fin),
        .wait_done     (wait_done),
        .dummy_pending (dummy_pending),
        .init_done     (init_done)
    );

    psram_strobe_gen #(
        .ACT_C (ACT_C),
        .WCP_C (WCP_C),
        .CNT_W (CNT_W)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .phase    (ph_q),
        .cnt      (cnt_q),
        .op_wr    (op_q.wr),
        .op_dummy (op_q.dummy),
        .stb      (stb),
        .last_o   (last_q)
    );

    assign req_ready   = (ph_q == PH_IDLE) && init_done;
    assign busy        = !req_ready;
    assign start_dummy = (ph_q == PH_IDLE) && dummy_pending;
    assign start_req   = req_valid && req_ready;

    always_comb begin
        ph_d      = ph_q;
        cnt_d     = cnt_q;
        dummy_fin = 1'b0;
        unique case (ph_q)
            PH_POWERUP: begin
                if (wait_done)
                    ph_d = PH_IDLE;
            end
            PH_IDLE: begin
                if (start_dummy || start_req) begin
                    ph_d  = PH_ACTIVE;
                    cnt_d = '0;
                end
            end
            PH_ACTIVE: begin
                if (cnt_q == CNT_W'(ACT_C - 1)) begin
                    ph_d  = PH_PRECHG;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            PH_PRECHG: begin
                if (cnt_q == CNT_W'(PRE_C - 1)) begin
                    ph_d      = PH_IDLE;
                    cnt_d     = '0;
                    dummy_fin = op_q.dummy;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: ph_d = PH_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_POWERUP;
            cnt_q <= '0;
            op_q  <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            if (start_dummy)
                op_q <= '{addr: '0, wr: 1'b0, wdata: '0, dummy: 1'b1};
            else if (start_req)
                op_q <= '{addr: req_addr, wr: req_wr, wdata: req_wdata, dummy: 1'b0};
        end
    end

    // capture at the edge that closes the chip-enable window
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= last_q && !op_q.wr && !op_q.dummy;
            if (last_q && !op_q.wr && !op_q.dummy)
                rsp_d_q <= mem_rdata;
        end
    end

    assign rsp_valid = rsp_v_q;
    assign rsp_rdata = rsp_d_q;
    assign mem_addr  = op_q.addr;
    assign mem_wdata = op_q.wdata;
    assign mem_dq_oe = stb.dq_oe;
    assign mem_ce_n  = stb.ce_n;
    assign mem_we_n  = stb.we_n;
    assign mem_oe_n  = stb.oe_n;

    // R9: an accepted request makes the block busy on the next cycle
    p_accept_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
        start_req |=> busy);

    // R2: all strobes quiet during the power-up wait
    p_powerup_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_POWERUP) |-> (mem_ce_n && mem_oe_n && mem_we_n));

    // R3: dummy cycles never produce a response
    p_no_rsp_before_init_r3: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !rsp_valid);

    // R6: a response follows a cycle with output enable active, chip now deselected
    p_rsp_after_oe_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (($past(mem_oe_n) == 1'b0) && mem_ce_n));

    // R8: address holds through the chip-enable window
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && ($past(mem_ce_n) == 1'b0)) |-> $stable(mem_addr));

    // R7: write data holds and is driven while the write strobe is low
    p_wdata_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && ($past(mem_we_n) == 1'b0)) |-> ($stable(mem_wdata) && mem_dq_oe));

endmodule

// File: tb/tb_psram_seq.sv
module tb_psram_seq;

    localparam int ACT_E   = 10;
    localparam int PRE_E   = 5;
    localparam int RC_E    = 16;
    localparam int WCP_E   = 6;
    localparam int PWR_E   = 300;
    localparam int DUMMY_E = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        busy, init_done;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_dq_oe;
    logic [7:0]  mem_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [7:0] model   [int];
    logic [7:0] exp_mem [int];
    logic [7:0] exp_q   [$];

    psram_seq #(.PWRUP_NS(3000)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .busy(busy), .init_done(init_done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_dq_oe(mem_dq_oe),
        .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        return model.exists(int'(a)) ? model[int'(a)] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [14:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    endfunction

    assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? model_rd(mem_addr) : 8'hA5;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- pin monitor ----------------
    int   cyc = 0;
    logic prev_ce = 1'b1;
    int   low_run = 0, high_run = 0, last_fall = 0, last_gap = 0, we_run = 0;
    bit   have_fall = 0, addr_bad = 0, oe_all = 0, oe_any = 0, we_any = 0;
    bit   we_gap = 0, dq_bad = 0, pre_init = 0, last_we_low = 0;
    logic [14:0] fall_addr = '0;
    int   dummy_pulses = 0;
    bit   init_seen = 0, r3_bad = 0, r9_bad = 0, rsp_twice = 0, prev_rsp = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    if (!have_fall)
                        chk(cyc >= PWR_E, "R2", "first chip-enable cycle", cyc, PWR_E);
                    else begin
                        chk(cyc - last_fall >= RC_E, "R5", "fall-to-fall", cyc - last_fall, RC_E);
                        chk(high_run >= PRE_E, "R5", "precharge cycles", high_run, PRE_E);
                        last_gap = cyc - last_fall;
                    end
                    have_fall = 1; last_fall = cyc; low_run = 0; fall_addr = mem_addr;
                    addr_bad = 0; oe_all = 1; oe_any = 0; we_run = 0; we_any = 0;
                    we_gap = 0; dq_bad = 0; pre_init = !init_done;
                end
                low_run++;
                if (mem_addr != fall_addr) addr_bad = 1;
                if (mem_oe_n) oe_all = 0; else oe_any = 1;
                if (!mem_we_n) begin
                    we_run++; we_any = 1;
                    if (!mem_dq_oe) dq_bad = 1;
                    model[int'(mem_addr)] = mem_wdata;
                end else if (we_any) we_gap = 1;
                last_we_low = !mem_we_n;
            end else begin
                if (!prev_ce) begin
                    chk(low_run == ACT_E, "R4", "chip-enable low cycles", low_run, ACT_E);
                    chk(!addr_bad, "R8", "address moved in window", addr_bad, 0);
                    if (pre_init) begin
                        dummy_pulses++;
                        chk(!we_any && !oe_any, "R3", "dummy strobe activity", {we_any, oe_any}, 0);
                    end else if (we_any) begin
                        chk(we_run == WCP_E, "R7", "write strobe cycles", we_run, WCP_E);
                        chk(last_we_low && !we_gap && !dq_bad && !oe_any, "R7",
                            "write strobe placement", {last_we_low, we_gap, dq_bad, oe_any}, 4'b1000);
                    end else begin
                        chk(oe_all, "R6", "output enable over read window", oe_all, 1);
                    end
                    high_run = 0;
                end
                high_run++;
            end
            prev_ce = mem_ce_n;

            if (busy == req_ready) r9_bad = 1;
            if (!init_done && (req_ready || rsp_valid)) r3_bad = 1;
            if (init_done && !init_seen) begin
                init_seen = 1;
                chk(dummy_pulses == DUMMY_E, "R3", "dummy pulses before init_done", dummy_pulses, DUMMY_E);
            end
            if (init_seen && !init_done) r3_bad = 1;

            if (rsp_valid) begin
                if (prev_rsp) rsp_twice = 1;
                chk(mem_ce_n, "R6", "chip deselected on response", mem_ce_n, 1);
                if (exp_q.size() == 0)
                    chk(1'b0, "R7", "response with no read pending", rsp_rdata, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) exp_mem[int'(a)] = d;
        else    exp_q.push_back(exp_rd(a));
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after acceptance", busy, 1);
    endtask

    logic [14:0] pool [16];

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) pool[i] = 15'($urandom);
        pool[0] = 15'h0000;
        pool[1] = 15'h7FFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dq_oe && !rsp_valid, "R1", "drive/response in reset", {mem_dq_oe, rsp_valid}, 0);
        chk(!req_ready && !init_done && busy, "R1", "handshake in reset", {req_ready, init_done, busy}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && !req_ready && busy && !init_done, "R1", "first cycle after reset",
            {mem_ce_n, req_ready, busy, init_done}, 4'b1010);

        while (!init_done) @(negedge clk);

        // directed corners: top and bottom addresses
        issue(1'b1, 15'h7FFF, 8'h5A);
        issue(1'b1, 15'h0000, 8'hC3);
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b0, 15'h0000, 8'h00);
        issue(1'b0, 15'h1234, 8'h00);   // never written: reads 0

        // R10: back-to-back with request held valid
        repeat (3) @(negedge clk);
        issue(1'b1, 15'h0042, 8'h99);
        issue(1'b0, 15'h0042, 8'h00);
        repeat (3) @(negedge clk);
        chk(last_gap == ACT_E + PRE_E + 1, "R10", "back-to-back spacing", last_gap, ACT_E + PRE_E + 1);

        // random mix
        for (int n = 0; n < 150; n++) begin
            bit          w;
            logic [14:0] a;
            w = 1'($urandom);
            a = ($urandom % 5 == 0) ? 15'($urandom) : pool[$urandom % 16];
            issue(w, a, 8'($urandom));
            repeat ($urandom % 4) @(negedge clk);
        end

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "reads left without response", exp_q.size(), 0);
        chk(!r3_bad, "R3", "ready/response before init or init fell", r3_bad, 0);
        chk(!r9_bad, "R9", "busy equals ready", r9_bad, 0);
        chk(!rsp_twice, "R6", "response longer than one cycle", rsp_twice, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule